// File: doc/BRIEF.md
# Character Cell Buffer for a Text Display

This block is the storage behind a text-mode screen of 30 rows by 80 columns. A processor writes character codes into it as a memory-mapped slave. Each cell takes one word slot in the address space, and only the low byte of the written word is kept. Every row is padded out to 128 word slots, so the column is taken straight from low address bits and the row from the bits above them. Slots past column 79, and rows past 29, hold nothing.

A second, independent read port serves a scan-out renderer. The renderer presents a row and a column and receives the stored character code one clock later. The bus and the renderer never stall each other. Every in-window bus request is acknowledged on the following clock. A read returns the code zero-extended to the full data width.

Top module: `glyph_grid_store`

## Requirements
- R1: While reset is held, and on the first clocks after it is released, `bus_ack` is 0 and both `bus_rdata` and `scan_char` are 0.
- R2: A write (`bus_req`=1, `bus_we`=1) to a visible cell stores bits [7:0] of `bus_wdata` in that cell. Bits [31:8] of the write data are discarded.
- R3: The byte address of cell (row, col) is 0x30100000 + (row*128 + col)*4. Address bits [8:2] select the column and bits [19:9] select the row. Bits [1:0] are ignored.
- R4: A write whose column is 80 or more, or whose row is 30 or more, changes no cell. In particular, column 80 of row r does not alias column 0 of row r+1.
- R5: A request whose address bits [31:20] differ from 0x301 is not acknowledged and stores nothing.
- R6: Every in-window request, read or write, gets `bus_ack`=1 exactly on the next clock. `bus_ack` is never 1 without an in-window request on the previous clock.
- R7: In the acknowledge cycle of a read, `bus_rdata` carries the stored code in bits [7:0] and zero in bits [31:8]. A read of an unused slot returns 0.
- R8: `scan_char` shows the code of cell (`scan_row`, `scan_col`) one clock after they are presented. For coordinates outside the visible area it shows 0.
- R9: If a scan read and a bus write hit the same cell on the same clock, the scan port returns the cell's previous contents, and the new code appears on the following scan read.
- R10: `bus_rdata` is 0 in every cycle except the acknowledge cycle of a read. This includes the acknowledge cycle of a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Bus request strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data, low byte is the character code |
| bus_ack | output | 1 | Acknowledge, one clock after an in-window request |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| scan_row | input | 5 | Renderer row |
| scan_col | input | 7 | Renderer column |
| scan_char | output | 8 | Character code, one clock after row and column |

## Verification
The assertions assume that `bus_we` and `bus_addr` carry known values whenever `bus_req` is high. They also assume that every in-window request expects its acknowledge on the next clock, with no wait states from elsewhere. The scan coordinates are checked against the output one clock later, so they must never be unknown once reset has been released. The bench drives all inputs on the falling edge and drops `bus_req` between accesses. It leaves scan coordinates at known in-range or deliberately out-of-range values, and it issues no request until the internal reset synchroniser has released.

// File: rtl/ggs_pkg.sv
package ggs_pkg;
  localparam int unsigned DEF_ROWS      = 30;
  localparam int unsigned DEF_COLS      = 80;
  localparam int unsigned DEF_ROW_SLOTS = 128;
  localparam int unsigned DEF_WIN_BITS  = 20;
  localparam int unsigned DEF_DATA_W    = 32;
  localparam int unsigned DEF_CHAR_W    = 8;
  localparam logic [31:0] DEF_BASE      = 32'h3010_0000;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;
endpackage

// File: rtl/ggs_rst_sync.sv
module ggs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_q_n = stage_q[1];
endmodule

// File: rtl/ggs_cell_index.sv
module ggs_cell_index #(
  parameter int unsigned ROWS  = 30,
  parameter int unsigned COLS  = 80,
  parameter int unsigned RW    = 5,
  parameter int unsigned CW    = 7,
  parameter int unsigned IDX_W = 12
) (
  input  logic [RW-1:0]    row,
  input  logic [CW-1:0]    col,
  output logic             in_area,
  output logic [IDX_W-1:0] idx
);
  localparam logic [RW-1:0]    ROW_LIM = RW'(ROWS);
  localparam logic [CW-1:0]    COL_LIM = CW'(COLS);
  localparam logic [IDX_W-1:0] STRIDE  = IDX_W'(COLS);

  logic [IDX_W-1:0] row_ext;
  logic [IDX_W-1:0] col_ext;

  always_comb begin
    row_ext = IDX_W'(row);
    col_ext = IDX_W'(col);
    in_area = (row < ROW_LIM) && (col < COL_LIM);
    idx     = row_ext * STRIDE + col_ext;
  end
endmodule

// File: rtl/ggs_bus_decode.sv
module ggs_bus_decode
  import ggs_pkg::*;
#(
  parameter logic [31:0] BASE      = DEF_BASE,
  parameter int unsigned WIN_BITS  = DEF_WIN_BITS,
  parameter int unsigned ROWS      = DEF_ROWS,
  parameter int unsigned COLS      = DEF_COLS,
  parameter int unsigned ROW_SLOTS = DEF_ROW_SLOTS,
  parameter int unsigned IDX_W     = 12
) (
  input  logic             req,
  input  logic             we,
  input  logic [31:0]      addr,
  output acc_kind_t        kind,
  output logic             cell_ok,
  output logic [IDX_W-1:0] idx
);
  localparam int unsigned COL_W = $clog2(ROW_SLOTS);
  localparam int unsigned ROW_W = WIN_BITS - 2 - COL_W;

  logic             in_win;
  logic [COL_W-1:0] col_f;
  logic [ROW_W-1:0] row_f;
  logic             area_ok;
  logic [1:0]       unused_byte_lane;

  assign in_win           = (addr[31:WIN_BITS] == BASE[31:WIN_BITS]);
  assign col_f            = addr[COL_W+1:2];
  assign row_f            = addr[WIN_BITS-1:COL_W+2];
  assign unused_byte_lane = addr[1:0];

  ggs_cell_index #(
    .ROWS(ROWS), .COLS(COLS), .RW(ROW_W), .CW(COL_W), .IDX_W(IDX_W)
  ) u_idx (
    .row(row_f), .col(col_f), .in_area(area_ok), .idx(idx)
  );

  always_comb begin
    kind = ACC_NONE;
    if (req && in_win) kind = we ? ACC_WRITE : ACC_READ;
    cell_ok = in_win && area_ok;
  end
endmodule

// File: rtl/ggs_cell_array.sv
module ggs_cell_array #(
  parameter int unsigned DEPTH  = 2400,
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned NRD    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [CHAR_W-1:0]          wr_data,
  input  logic [NRD-1:0]             rd_en,
  input  logic [NRD-1:0]             rd_ok,
  input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
  output logic [NRD-1:0][CHAR_W-1:0] rd_data
);
  logic [CHAR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic              fetch;
    logic              hit_d, hit_q;
    logic [CHAR_W-1:0] q_d, q_q;

    always_comb begin
      fetch = rd_en[p] && rd_ok[p];
      hit_d = fetch;
      q_d   = q_q;
      if (fetch) q_d = mem[rd_idx[p]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q <= 1'b0;
        q_q   <= '0;
      end else begin
        hit_q <= hit_d;
        q_q   <= q_d;
      end
    end

    assign rd_data[p] = hit_q ? q_q : '0;
  end
endmodule

// File: rtl/glyph_grid_store.sv
module glyph_grid_store
  import ggs_pkg::*;
#(
  parameter logic [31:0] BASE      = DEF_BASE,
  parameter int unsigned WIN_BITS  = DEF_WIN_BITS,
  parameter int unsigned ROWS      = DEF_ROWS,
  parameter int unsigned COLS      = DEF_COLS,
  parameter int unsigned ROW_SLOTS = DEF_ROW_SLOTS,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned CHAR_W    = DEF_CHAR_W,
  localparam int unsigned SR_W     = $clog2(ROWS),
  localparam int unsigned SC_W     = $clog2(ROW_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [31:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SR_W-1:0]   scan_row,
  input  logic [SC_W-1:0]   scan_col,
  output logic [CHAR_W-1:0] scan_char
);
  localparam int unsigned DEPTH  = ROWS * COLS;
  localparam int unsigned IDX_W  = $clog2(DEPTH);
  localparam int unsigned P_BUS  = 0;
  localparam int unsigned P_SCAN = 1;

  logic                       rst_q_n;
  acc_kind_t                  kind;
  logic                       bus_cell_ok;
  logic [IDX_W-1:0]           bus_idx;
  logic                       scan_ok;
  logic [IDX_W-1:0]           scan_idx;
  logic                       wr_en;
  logic [1:0]                 rd_en, rd_ok;
  logic [1:0][IDX_W-1:0]      rd_idx;
  logic [1:0][CHAR_W-1:0]     rd_data;
  logic                       ack_d, ack_q;
  logic                       rd_d, rd_q;
  logic [DATA_W-CHAR_W-1:0]   unused_wdata_hi;

  assign unused_wdata_hi = bus_wdata[DATA_W-1:CHAR_W];

  ggs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  ggs_bus_decode #(
    .BASE(BASE), .WIN_BITS(WIN_BITS), .ROWS(ROWS), .COLS(COLS),
    .ROW_SLOTS(ROW_SLOTS), .IDX_W(IDX_W)
  ) u_dec (
    .req(bus_req), .we(bus_we), .addr(bus_addr),
    .kind(kind), .cell_ok(bus_cell_ok), .idx(bus_idx)
  );

  ggs_cell_index #(
    .ROWS(ROWS), .COLS(COLS), .RW(SR_W), .CW(SC_W), .IDX_W(IDX_W)
  ) u_scan_idx (
    .row(scan_row), .col(scan_col), .in_area(scan_ok), .idx(scan_idx)
  );

  always_comb begin
    wr_en          = (kind == ACC_WRITE) && bus_cell_ok;
    rd_en[P_BUS]   = (kind == ACC_READ);
    rd_ok[P_BUS]   = bus_cell_ok;
    rd_idx[P_BUS]  = bus_idx;
    rd_en[P_SCAN]  = 1'b1;
    rd_ok[P_SCAN]  = scan_ok;
    rd_idx[P_SCAN] = scan_idx;
    ack_d          = (kind != ACC_NONE);
    rd_d           = (kind == ACC_READ);
  end

  ggs_cell_array #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CHAR_W(CHAR_W), .NRD(2)
  ) u_cells (
    .clk(clk), .rst_n(rst_q_n),
    .wr_en(wr_en), .wr_idx(bus_idx), .wr_data(bus_wdata[CHAR_W-1:0]),
    .rd_en(rd_en), .rd_ok(rd_ok), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ack_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      ack_q <= ack_d;
      rd_q  <= rd_d;
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = (ack_q && rd_q) ? {{(DATA_W-CHAR_W){1'b0}}, rd_data[P_BUS]} : '0;
  assign scan_char = rd_data[P_SCAN];
endmodule

// File: rtl/glyph_grid_store_chk.sv
module glyph_grid_store_chk #(
  parameter logic [31:0] BASE      = 32'h3010_0000,
  parameter int unsigned WIN_BITS  = 20,
  parameter int unsigned ROWS      = 30,
  parameter int unsigned COLS      = 80,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CHAR_W    = 8,
  parameter int unsigned SR_W      = 5,
  parameter int unsigned SC_W      = 7
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [31:0]       bus_addr,
  input logic              bus_ack,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [SR_W-1:0]   scan_row,
  input logic [SC_W-1:0]   scan_col,
  input logic [CHAR_W-1:0] scan_char
);
  logic armed;
  logic hit_win;
  logic scan_out;

  assign hit_win  = bus_req && (bus_addr[31:WIN_BITS] == BASE[31:WIN_BITS]);
  assign scan_out = (32'(scan_row) >= ROWS) || (32'(scan_col) >= COLS);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    hit_win |=> bus_ack); // R6
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_q_n)
    (armed && bus_ack) |-> $past(hit_win)); // R6
  AST_RDATA_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_q_n)
    bus_ack |-> (bus_rdata[DATA_W-1:CHAR_W] == '0)); // R7
  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    !bus_ack |-> (bus_rdata == '0)); // R10
  AST_WRITE_ACK_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (armed && bus_ack && $past(bus_we)) |-> (bus_rdata == '0)); // R10
  AST_SCAN_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (armed && $past(scan_out)) |-> (scan_char == '0)); // R8
endmodule

bind glyph_grid_store glyph_grid_store_chk #(
  .BASE(BASE), .WIN_BITS(WIN_BITS), .ROWS(ROWS), .COLS(COLS),
  .DATA_W(DATA_W), .CHAR_W(CHAR_W), .SR_W(SR_W), .SC_W(SC_W)
) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
  .scan_row(scan_row), .scan_col(scan_col), .scan_char(scan_char)
);

// File: tb/tb_glyph_grid_store.sv
module tb_glyph_grid_store;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_ack;
  logic [4:0]  scan_row;
  logic [6:0]  scan_col;
  logic [7:0]  scan_char;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  glyph_grid_store dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .scan_row(scan_row), .scan_col(scan_col),
    .scan_char(scan_char)
  );

  function automatic logic [31:0] cell_addr(input int row, input int col);
    return 32'h3010_0000 + 32'((row * 128 + col) * 4);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_op(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        output logic ack, output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
    @(negedge clk);
    ack = bus_ack; rd = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic scan_at(input int row, input int col, output logic [7:0] ch);
    @(negedge clk);
    scan_row = 5'(row); scan_col = 7'(col);
    @(negedge clk);
    ch = scan_char;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    scan_row = '0; scan_col = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bus_ack == 1'b0, "R1 ack in reset", 32'(bus_ack), 0);
    check(bus_rdata == '0, "R1 rdata in reset", bus_rdata, 0);
    check(scan_char == '0, "R1 scan in reset", 32'(scan_char), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_ack == 1'b0 && scan_char == '0, "R1 after release",
          {23'b0, bus_ack, scan_char}, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_write_scan;
    logic a; logic [31:0] r; logic [7:0] ch;
    bus_op(1, cell_addr(0, 0), 32'h0000_0041, a, r);
    check(a == 1'b1, "R6 write ack", 32'(a), 1);
    check(r == '0, "R10 rdata on write ack", r, 0);
    bus_op(1, cell_addr(29, 79), 32'hDEAD_BE7A, a, r);
    bus_op(1, cell_addr(12, 40) | 32'h3, 32'h1234_5663, a, r);
    scan_at(0, 0, ch);
    check(ch == 8'h41, "R2 cell 0,0", 32'(ch), 32'h41);
    scan_at(29, 79, ch);
    check(ch == 8'h7A, "R2 last cell low byte", 32'(ch), 32'h7A);
    scan_at(12, 40, ch);
    check(ch == 8'h63, "R3 mid cell, byte lane ignored", 32'(ch), 32'h63);
  endtask

  task automatic t_bus_read;
    logic a; logic [31:0] r;
    bus_op(1, cell_addr(7, 3), 32'hFFFF_FFC8, a, r);
    bus_op(0, cell_addr(7, 3), 32'hFFFF_FFFF, a, r);
    check(a == 1'b1, "R6 read ack", 32'(a), 1);
    check(r == 32'h0000_00C8, "R7 zero-extended read", r, 32'hC8);
    @(negedge clk);
    check(bus_ack == 1'b0 && bus_rdata == '0, "R10 idle after read", bus_rdata, 0);
    bus_op(0, cell_addr(7, 100), 32'h0, a, r);
    check(a == 1'b1 && r == '0, "R7 unused slot reads zero", r, 0);
  endtask

  task automatic t_drop;
    logic a; logic [31:0] r; logic [7:0] ch;
    bus_op(1, cell_addr(1, 0), 32'h11, a, r);
    bus_op(1, cell_addr(0, 80), 32'h99, a, r);
    check(a == 1'b1, "R6 ack on dropped column", 32'(a), 1);
    scan_at(1, 0, ch);
    check(ch == 8'h11, "R4 column 80 no alias", 32'(ch), 32'h11);
    bus_op(1, cell_addr(0, 127), 32'h98, a, r);
    scan_at(0, 47, ch);
    check(ch !== 8'h98 || 1'b0, "R4 column 127 dropped (probe)", 32'(ch), 0);
    bus_op(0, cell_addr(0, 80), 32'h0, a, r);
    check(r == '0, "R4 column 80 reads zero", r, 0);
    bus_op(1, cell_addr(30, 0), 32'h77, a, r);
    bus_op(0, cell_addr(30, 0), 32'h0, a, r);
    check(r == '0, "R4 row 30 reads zero", r, 0);
    bus_op(1, cell_addr(29, 79), 32'h55, a, r);
    bus_op(1, cell_addr(2000, 5), 32'h66, a, r);
    scan_at(29, 79, ch);
    check(ch == 8'h55, "R4 high row does not disturb last cell", 32'(ch), 32'h55);
  endtask

  task automatic t_outside;
    logic a; logic [31:0] r; logic [7:0] ch;
    bus_op(1, cell_addr(4, 4), 32'h21, a, r);
    bus_op(1, 32'h3020_0000 + 32'((4 * 128 + 4) * 4), 32'h5E, a, r);
    check(a == 1'b0, "R5 no ack above window", 32'(a), 0);
    bus_op(1, 32'h3000_0000 + 32'((4 * 128 + 4) * 4), 32'h5F, a, r);
    check(a == 1'b0, "R5 no ack below window", 32'(a), 0);
    scan_at(4, 4, ch);
    check(ch == 8'h21, "R5 outside write stores nothing", 32'(ch), 32'h21);
  endtask

  task automatic t_scan_outside;
    logic [7:0] ch;
    scan_at(30, 0, ch);
    check(ch == 8'h00, "R8 row 30 scans zero", 32'(ch), 0);
    scan_at(3, 90, ch);
    check(ch == 8'h00, "R8 column 90 scans zero", 32'(ch), 0);
  endtask

  task automatic t_collision;
    logic [7:0] ch;
    logic a; logic [31:0] r;
    bus_op(1, cell_addr(20, 10), 32'h30, a, r);
    @(negedge clk);
    scan_row = 5'd20; scan_col = 7'd10;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = cell_addr(20, 10); bus_wdata = 32'h31;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    check(scan_char == 8'h30, "R9 same-cycle scan sees old", 32'(scan_char), 32'h30);
    @(negedge clk);
    check(scan_char == 8'h31, "R9 next scan sees new", 32'(scan_char), 32'h31);
  endtask

  initial begin
    t_reset;
    t_write_scan;
    t_bus_read;
    t_drop;
    t_outside;
    t_scan_outside;
    t_collision;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule